// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio D = N*P + S. A dual-modulus prescaler counts input-clock cycles and emits a tick every N or N+1 cycles. The modulus-control signal picks which of the two. A single up counter counts prescaler ticks. Its next value is checked against one compare target, taken from a two-way multiplexer: first the swallow word S, then the program word P.

While the count is below S, the prescaler runs at N+1. When the count reaches S, modulus control drops and the multiplexer switches over to P. When the count reaches P, the counter returns to zero and the output pulses. The period then holds (N+1)*S + N*(P-S) input cycles. The prescaler modulus N is a parameter, intended values 4, 16 and 32. Both words are captured only at the output-period boundary, so a change in the middle of a period takes effect with the next period.

The whole block is synchronous to the input clock and has a synchronous reset. Legal settings are P >= 1 and 0 <= S < P.

Top module: `pulse_swallow_div`

## Requirements
- R1: The distance between consecutive rising edges of `div_out`, counted in input-clock cycles, is N*P + S.
- R2: In each output period, `mod_ctl` is 1 for the first (N+1)*S input cycles, starting with the cycle in which `div_out` is high. It is 0 for the remaining N*(P-S) cycles.
- R3: When S = 0, `mod_ctl` stays 0 for the whole period and the period is N*P cycles. This includes the reset state.
- R4: `div_out` is high for exactly one input-clock cycle per output period.
- R5: `p_word` and `s_word` are captured only on the cycle that ends an output period. A change during a period leaves that period's length unchanged, and the next period uses the new values.
- R6: While `rst_sync` is 1, `div_out` is 0 and `mod_ctl` is 1 if `s_word` is nonzero, else 0. The first `div_out` pulse appears N*P + S cycles after reset is released.
- R7: The extreme settings P = 1, S = 0 (period N) and S = P-1 (period N*P + P - 1) follow R1 and R2.
- R8: The prescaler modulus is set by parameter `PRESC_N`. The values 4, 16 and 32 each give the ratios of R1 and R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Fast input clock to be divided |
| rst_sync | input | 1 | Synchronous reset, active high |
| p_word | input | CNT_W | Program word P (must be at least 1) |
| s_word | input | CNT_W | Swallow word S (must be below P) |
| div_out | output | 1 | One-cycle pulse per output period |
| mod_ctl | output | 1 | Prescaler modulus select, 1 = divide by N+1 |

## Verification
A wrong internal count, a stale compare target or a modulus flag stuck in the wrong state changes the length of the very next output period. The error also shows in how many cycles of that period `mod_ctl` is high, so it is visible at the next `div_out` pulse, within N*P + S cycles. The bench measures both quantities every period for all three prescaler moduli. A capture that happens at the wrong time shows up as a wrong length in the period that spans a word change.

// File: rtl/pd_pkg.sv
package pd_pkg;
    // Which word the shared counter is currently compared against
    typedef enum logic {
        PH_SWALLOW = 1'b0,
        PH_MAIN    = 1'b1
    } phase_t;
endpackage

// File: rtl/pd_eq_det.sv
module pd_eq_det #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq
);
    logic [W-1:0] diff;

    // Bitwise XOR, then an OR reduction over the differences
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign diff[i] = a[i] ^ b[i];
    end

    assign eq = ~|diff;
endmodule

// File: rtl/pd_prescaler.sv
module pd_prescaler #(
    parameter int N = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic mc,
    output logic tick
);
    localparam int PW = $clog2(N + 1);
    localparam logic [PW-1:0] LAST_LONG  = PW'(N);
    localparam logic [PW-1:0] LAST_SHORT = PW'(N - 1);

    typedef struct packed {
        logic [PW-1:0] pc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.pc == (mc ? LAST_LONG : LAST_SHORT));
        if (tick) begin
            st_d.pc = '0;
        end else begin
            st_d.pc = st_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Ticks are at least N >= 2 cycles apart
    p_tick_apart_r1: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // The counter never passes the long terminal value
    p_pc_bound_r8: assert property (@(posedge clk) disable iff (rst)
        st_q.pc <= LAST_LONG);
endmodule

// File: rtl/pd_swallow_ctrl.sv
module pd_swallow_ctrl
    import pd_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] p_in,
    input  logic [CW-1:0] s_in,
    output logic          mc,
    output logic          pulse
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] p_lat;
        logic [CW-1:0] s_lat;
        phase_t        ph;
        logic          mc;
        logic          pulse;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] cnt_nxt;
    logic [CW-1:0] target;
    logic          hit;

    assign cnt_nxt = st_q.cnt + 1'b1;
    // Compare-target multiplexer: swallow word first, then program word
    assign target  = (st_q.ph == PH_MAIN) ? st_q.p_lat : st_q.s_lat;

    pd_eq_det #(.W(CW)) eq_i (
        .a  (cnt_nxt),
        .b  (target),
        .eq (hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (tick) begin
            st_d.cnt = cnt_nxt;
            if (hit) begin
                if (st_q.ph == PH_SWALLOW) begin
                    st_d.ph = PH_MAIN;
                    st_d.mc = 1'b0;
                end else begin
                    st_d.cnt   = '0;
                    st_d.pulse = 1'b1;
                    st_d.p_lat = p_in;
                    st_d.s_lat = s_in;
                    st_d.mc    = (s_in != '0);
                    st_d.ph    = (s_in == '0) ? PH_MAIN : PH_SWALLOW;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.cnt   <= '0;
            st_q.p_lat <= p_in;
            st_q.s_lat <= s_in;
            st_q.mc    <= (s_in != '0);
            st_q.ph    <= (s_in == '0) ? PH_MAIN : PH_SWALLOW;
            st_q.pulse <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mc    = st_q.mc;
    assign pulse = st_q.pulse;

    // Modulus control drops only on a prescaler tick
    p_mc_fall_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(st_q.mc) |-> $past(tick));

    // Modulus control rises only when a new period starts
    p_mc_rise_at_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.mc) |-> st_q.pulse);

    // The captured words change only at a period boundary
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(st_q.p_lat) || !$stable(st_q.s_lat)) |-> st_q.pulse);

    // A zero swallow word keeps the prescaler in divide-by-N
    p_s_zero_low_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q.s_lat == '0) |-> !st_q.mc);

    // Output pulse lasts one cycle
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
        st_q.pulse |=> !st_q.pulse);

    // Counter stays below the captured program word
    p_cnt_below_p_r1: assert property (@(posedge clk) disable iff (rst)
        (st_q.p_lat != '0) |-> (st_q.cnt < st_q.p_lat));
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div #(
    parameter int PRESC_N = 16,
    parameter int CNT_W   = 8
) (
    input  logic             clk_fast,
    input  logic             rst_sync,
    input  logic [CNT_W-1:0] p_word,
    input  logic [CNT_W-1:0] s_word,
    output logic             div_out,
    output logic             mod_ctl
);
    logic presc_tick;
    logic mc_w;

    pd_prescaler #(.N(PRESC_N)) presc_i (
        .clk  (clk_fast),
        .rst  (rst_sync),
        .mc   (mc_w),
        .tick (presc_tick)
    );

    pd_swallow_ctrl #(.CW(CNT_W)) ctrl_i (
        .clk   (clk_fast),
        .rst   (rst_sync),
        .tick  (presc_tick),
        .p_in  (p_word),
        .s_in  (s_word),
        .mc    (mc_w),
        .pulse (div_out)
    );

    assign mod_ctl = mc_w;
endmodule

// File: tb/pulse_swallow_div_tb_top.sv
module pulse_swallow_div_tb_top;
    localparam int CW = 8;
    localparam int NV [3] = '{4, 16, 32};

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst = 1'b1;
    logic [CW-1:0] p_w = 8'd5;
    logic [CW-1:0] s_w = 8'd2;
    logic [2:0]    div_w, mc_w;

    int checks = 0;
    int failures = 0;

    pulse_swallow_div #(.PRESC_N(4), .CNT_W(CW)) dut_n4_i (
        .clk_fast(clk), .rst_sync(rst), .p_word(p_w), .s_word(s_w),
        .div_out(div_w[0]), .mod_ctl(mc_w[0]));
    pulse_swallow_div #(.PRESC_N(16), .CNT_W(CW)) dut_i (
        .clk_fast(clk), .rst_sync(rst), .p_word(p_w), .s_word(s_w),
        .div_out(div_w[1]), .mod_ctl(mc_w[1]));
    pulse_swallow_div #(.PRESC_N(32), .CNT_W(CW)) dut_n32_i (
        .clk_fast(clk), .rst_sync(rst), .p_word(p_w), .s_word(s_w),
        .div_out(div_w[2]), .mod_ctl(mc_w[2]));

    // Period monitor, sampling at the falling edge
    int   gap [3], last_int [3], hi [3], last_hi [3], npulse [3], wide [3];
    logic prev_div [3];
    initial for (int i = 0; i < 3; i++) begin
        gap[i] = 0; last_int[i] = 0; hi[i] = 0; last_hi[i] = 0;
        npulse[i] = 0; wide[i] = 0; prev_div[i] = 1'b0;
    end

    always @(negedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (rst) begin
                gap[i] = 0; hi[i] = 0; npulse[i] = 0;
            end else begin
                gap[i] = gap[i] + 1;
                if (div_w[i]) begin
                    if (prev_div[i]) wide[i] = wide[i] + 1;
                    last_int[i] = gap[i];
                    gap[i]      = 0;
                    last_hi[i]  = hi[i];
                    hi[i]       = int'(mc_w[i]);
                    npulse[i]   = npulse[i] + 1;
                end else begin
                    hi[i] = hi[i] + int'(mc_w[i]);
                end
            end
            prev_div[i] = div_w[i];
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(int p, int s);
        @(negedge clk);
        #1;
        p_w = CW'(p);
        s_w = CW'(s);
    endtask

    task automatic wait_one(int i, int n);
        int base;
        base = npulse[i];
        while (npulse[i] < base + n) @(posedge clk);
    endtask

    task automatic wait_all(int n);
        int base [3];
        for (int i = 0; i < 3; i++) base[i] = npulse[i];
        for (int i = 0; i < 3; i++)
            while (npulse[i] < base[i] + n) @(posedge clk);
    endtask

    // R6 (and R3 when s = 0): reset outputs and first period after release
    task automatic t_reset(int p, int s);
        @(negedge clk);
        #1;
        rst = 1'b1;
        p_w = CW'(p);
        s_w = CW'(s);
        repeat (3) @(negedge clk);
        #1;
        for (int i = 0; i < 3; i++) begin
            check($sformatf("R6 div_out in reset N=%0d", NV[i]), int'(div_w[i]), 0);
            check($sformatf("R6 mod_ctl in reset N=%0d", NV[i]), int'(mc_w[i]), (s != 0) ? 1 : 0);
        end
        rst = 1'b0;
        wait_all(1);
        for (int i = 0; i < 3; i++)
            check($sformatf("R6 first period N=%0d", NV[i]), last_int[i], NV[i] * p + s);
    endtask

    // R1, R2, R8: steady-state period and modulus-control duty
    task automatic t_setting(int p, int s, string tag);
        drive(p, s);
        wait_all(2);
        for (int i = 0; i < 3; i++) begin
            check($sformatf("R1 R8 %s period N=%0d", tag, NV[i]), last_int[i], NV[i] * p + s);
            check($sformatf("R2 %s mod_ctl high N=%0d", tag, NV[i]), last_hi[i], (NV[i] + 1) * s);
        end
    endtask

    // R5: a word change in mid-period takes effect on the next period
    task automatic t_midchange();
        drive(6, 3);
        wait_all(2);
        repeat (10) @(negedge clk);
        drive(9, 1);
        wait_one(1, 1);
        check("R5 period spanning change", last_int[1], 16 * 6 + 3);
        wait_one(1, 1);
        check("R5 period after change", last_int[1], 16 * 9 + 1);
    endtask

    initial begin
        t_reset(5, 2);
        t_setting(7, 0, "R3 s=0");
        t_setting(10, 9, "R7 s=p-1");
        t_setting(1, 0, "R7 p=1");
        t_setting(20, 13, "mixed");
        t_setting(3, 1, "small");
        t_midchange();
        t_reset(3, 0);
        for (int i = 0; i < 3; i++)
            check($sformatf("R4 wide pulses N=%0d", NV[i]), wide[i], 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule